// File: doc/BRIEF.md
# Double-Precision NaN Classify-and-Quiet Unit

This unit inspects one 64-bit binary64 operand for each accepted strobe. It sorts the operand into one of six classes and repairs signaling NaNs. A floating-point datapath places it in front of its arithmetic so that every operand arrives already classified. Any signaling NaN is replaced by a quiet one before it can spread.

The rule for reading the top fraction bit (bit 51) is chosen per operand by a mode input. In the modern convention (`std_mode` = 1), a set bit 51 marks a quiet NaN. A signaling NaN is then quieted by forcing bit 51 to 1, which keeps its sign and payload. In the legacy convention (`std_mode` = 0), the meaning of bit 51 is inverted. A signaling NaN is then replaced by the fixed default NaN 0x7FF7_FFFF_FFFF_FFFF.

The unit registers its results one clock after the strobe. A signaling NaN raises a single-cycle invalid-operation pulse. Collecting that pulse into a flag register is left to the surrounding logic.

Top module: `dp_nan_quieter`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `invalid_pulse`, `class_onehot` and `result` are all zero.
- R2: `out_valid` is high in the cycle after each cycle in which `in_valid` is sampled high, and low after a cycle with `in_valid` low.
- R3: A non-NaN operand is classed by its exponent field (bits 62:52) and fraction field (bits 51:0). Exponent zero with fraction zero gives zero (class bit 0). Exponent zero with a nonzero fraction gives denormal (bit 1). An exponent neither zero nor all ones gives normal (bit 2). Exponent all ones with fraction zero gives infinity (bit 3).
- R4: An operand with exponent all ones and a nonzero fraction is a NaN. It is signaling (class bit 5) when `std_mode` XOR bit 51 equals 1, and quiet (class bit 4) otherwise.
- R5: Whenever `out_valid` is high, exactly one bit of `class_onehot` is set.
- R6: For a signaling NaN with `std_mode` = 1, `result` equals the operand with bit 51 set. All other bits are unchanged.
- R7: For a signaling NaN with `std_mode` = 0, `result` equals 0x7FF7_FFFF_FFFF_FFFF, regardless of the operand's sign and payload.
- R8: For any operand that is not a signaling NaN, `result` equals the operand unchanged.
- R9: `invalid_pulse` is high for exactly the one output cycle of each accepted signaling NaN, and is low in every other cycle.
- R10: While `in_valid` is low, `class_onehot` and `result` keep their last values, whatever `operand` and `std_mode` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| std_mode | input | 1 | 1 = modern NaN convention, 0 = legacy |
| operand | input | 64 | binary64 operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| class_onehot | output | 6 | One-hot class: 0 zero, 1 denormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN |
| result | output | 64 | Operand or its quieted replacement |
| invalid_pulse | output | 1 | One-cycle invalid-operation pulse |

## Verification
Classification and quieting fall in the same output cycle for every signaling NaN. The class bit, the replaced result and the invalid pulse must then agree with one another under the mode that was sampled together with that operand. This case is provoked by back-to-back strobes that alternate the mode on the same NaN bit patterns. Under the two modes, a single value can be quiet in one cycle and signaling in the next. On every clock, a behavioural model in the bench compares all four outputs, and each mismatch is reported under its own requirement.

// File: rtl/dp_nan_pkg.sv
package dp_nan_pkg;

    localparam int CLASS_N    = 6;
    localparam int CLS_ZERO   = 0;
    localparam int CLS_DENORM = 1;
    localparam int CLS_NORMAL = 2;
    localparam int CLS_INF    = 3;
    localparam int CLS_QNAN   = 4;
    localparam int CLS_SNAN   = 5;

    typedef logic [CLASS_N-1:0] class_vec_t;

endpackage

// File: rtl/dp_nan_classify.sv
module dp_nan_classify
    import dp_nan_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W-1:0] mag,
    input  logic                    std_mode,
    output class_vec_t              cls,
    output logic                    is_snan
);
    localparam int QBIT = FRAC_W - 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic exp_zero, exp_ones, frac_zero, nan_any;

    assign exp_f     = mag[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_f    = mag[FRAC_W-1:0];
    assign exp_zero  = (exp_f == '0);
    assign exp_ones  = (exp_f == '1);
    assign frac_zero = (frac_f == '0);
    assign nan_any   = exp_ones && !frac_zero;
    assign is_snan   = nan_any && (std_mode ^ frac_f[QBIT]);

    always_comb begin
        cls = '0;
        unique case (1'b1)
            exp_zero && frac_zero:  cls[CLS_ZERO]   = 1'b1;
            exp_zero && !frac_zero: cls[CLS_DENORM] = 1'b1;
            exp_ones && frac_zero:  cls[CLS_INF]    = 1'b1;
            nan_any && is_snan:     cls[CLS_SNAN]   = 1'b1;
            nan_any && !is_snan:    cls[CLS_QNAN]   = 1'b1;
            default:                cls[CLS_NORMAL] = 1'b1;
        endcase
    end
endmodule

// File: rtl/dp_nan_repair.sv
module dp_nan_repair #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] value_in,
    input  logic                  std_mode,
    input  logic                  is_snan,
    output logic [EXP_W+FRAC_W:0] value_out
);
    localparam int W    = EXP_W + FRAC_W + 1;
    localparam int QBIT = FRAC_W - 1;
    localparam logic [W-1:0] LEGACY_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
    localparam logic [W-1:0] QMASK = {{(W-1){1'b0}}, 1'b1} << QBIT;

    always_comb begin
        if (!is_snan)
            value_out = value_in;
        else if (std_mode)
            value_out = value_in | QMASK;
        else
            value_out = LEGACY_NAN;
    end
endmodule

// File: rtl/dp_nan_quieter.sv
module dp_nan_quieter
    import dp_nan_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    std_mode,
    input  logic [EXP_W+FRAC_W:0]   operand,
    output logic                    out_valid,
    output logic [CLASS_N-1:0]      class_onehot,
    output logic [EXP_W+FRAC_W:0]   result,
    output logic                    invalid_pulse
);
    localparam int W = EXP_W + FRAC_W + 1;

    class_vec_t     cls_d;
    logic           snan_d;
    logic [W-1:0]   res_d;

    dp_nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .mag      (operand[W-2:0]),
        .std_mode (std_mode),
        .cls      (cls_d),
        .is_snan  (snan_d)
    );

    dp_nan_repair #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_repair (
        .value_in  (operand),
        .std_mode  (std_mode),
        .is_snan   (snan_d),
        .value_out (res_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            invalid_pulse <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            invalid_pulse <= in_valid && snan_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            class_onehot <= '0;
            result       <= '0;
        end else if (in_valid) begin
            class_onehot <= cls_d;
            result       <= res_d;
        end
    end
endmodule

// File: rtl/dp_nan_quieter_chk.sv
module dp_nan_quieter_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  std_mode,
    input logic [EXP_W+FRAC_W:0] operand,
    input logic                  out_valid,
    input logic [5:0]            class_onehot,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  invalid_pulse
);
    localparam int W    = EXP_W + FRAC_W + 1;
    localparam int QBIT = FRAC_W - 1;
    localparam logic [W-1:0] LEGACY_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(class_onehot) == 1); // R5
    AST_INVALID_IS_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_pulse |-> (out_valid && class_onehot[5])); // R9
    AST_SNAN_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && class_onehot[5]) |-> invalid_pulse); // R4
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (invalid_pulse || result == $past(operand))); // R8
    AST_QUIET_MODERN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && std_mode) |=>
            (!invalid_pulse || (result[QBIT] &&
             result == ($past(operand) | (W'(1) << QBIT))))); // R6
    AST_QUIET_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !std_mode) |=> (!invalid_pulse || result == LEGACY_NAN)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(class_onehot))); // R10
endmodule

bind dp_nan_quieter dp_nan_quieter_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .std_mode      (std_mode),
    .operand       (operand),
    .out_valid     (out_valid),
    .class_onehot  (class_onehot),
    .result        (result),
    .invalid_pulse (invalid_pulse)
);

// File: tb/dp_nan_quieter_test.sv
module dp_nan_quieter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        std_mode = 1'b0;
    logic [63:0] operand = '0;
    logic        out_valid;
    logic [5:0]  class_onehot;
    logic [63:0] result;
    logic        invalid_pulse;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state
    bit          m_ov = 0, m_inv = 0;
    logic [5:0]  m_cls = '0;
    logic [63:0] m_res = '0;
    int          m_kind = 0; // 0 plain, 1 modern quiet, 2 legacy quiet

    always #2.5 clk = ~clk;

    dp_nan_quieter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .std_mode(std_mode),
        .operand(operand), .out_valid(out_valid), .class_onehot(class_onehot),
        .result(result), .invalid_pulse(invalid_pulse)
    );

    function automatic int ref_class(input logic [63:0] x, input bit m);
        int e;
        longint unsigned f;
        e = int'(x[62:52]);
        f = longint'(x[51:0]);
        if (e == 0) return (f == 0) ? 0 : 1;
        if (e != 2047) return 2;
        if (f == 0) return 3;
        return ((m ? 1 : 0) != (x[51] ? 1 : 0)) ? 5 : 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ov = 0; m_inv = 0; m_cls = '0; m_res = '0; m_kind = 0;
        end else if (in_valid) begin
            int c;
            c = ref_class(operand, std_mode);
            m_ov = 1;
            m_cls = 6'(1 << c);
            m_inv = (c == 5);
            if (c != 5) begin m_res = operand; m_kind = 0; end
            else if (std_mode) begin m_res = operand | 64'h0008_0000_0000_0000; m_kind = 1; end
            else begin m_res = 64'h7FF7_FFFF_FFFF_FFFF; m_kind = 2; end
        end else begin
            m_ov = 0; m_inv = 0;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            check("R1 out_valid", 64'(out_valid), 64'd0);
            check("R1 invalid_pulse", 64'(invalid_pulse), 64'd0);
            check("R1 class", 64'(class_onehot), 64'd0);
            check("R1 result", result, 64'd0);
        end else begin
            check("R2 out_valid", 64'(out_valid), 64'(m_ov));
            check("R9 invalid_pulse", 64'(invalid_pulse), 64'(m_inv));
            if (!m_ov) begin
                check("R10 class hold", 64'(class_onehot), 64'(m_cls));
                check("R10 result hold", result, m_res);
            end else begin
                check((m_cls[5] || m_cls[4]) ? "R4 class" : "R3 class",
                      64'(class_onehot), 64'(m_cls));
                check("R5 onehot", 64'($countones(class_onehot)), 64'd1);
                check(m_kind == 1 ? "R6 result" : (m_kind == 2 ? "R7 result" : "R8 result"),
                      result, m_res);
            end
        end
    end

    task automatic put(input bit v, input bit m, input logic [63:0] x);
        @(negedge clk);
        #1;
        in_valid = v; std_mode = m; operand = x;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R3 classes
        put(1, 0, 64'h0000_0000_0000_0000);
        put(1, 1, 64'h8000_0000_0000_0000);
        put(1, 0, 64'h0000_0000_0000_0001);
        put(1, 1, 64'h800F_FFFF_FFFF_FFFF);
        put(1, 0, 64'h0010_0000_0000_0000);
        put(1, 1, 64'h7FEF_FFFF_FFFF_FFFF);
        put(1, 0, 64'h3FF0_0000_0000_0000);
        put(1, 0, 64'h7FF0_0000_0000_0000);
        put(1, 1, 64'hFFF0_0000_0000_0000);
        // R4 with R6/R7: same patterns, alternating mode back-to-back
        put(1, 1, 64'h7FF8_0000_0000_0000);
        put(1, 0, 64'h7FF8_0000_0000_0000);
        put(1, 1, 64'hFFF0_0000_0000_0001);
        put(1, 0, 64'hFFF0_0000_0000_0001);
        put(1, 1, 64'hFFF4_ABCD_0123_4567);
        put(1, 0, 64'hFFFC_ABCD_0123_4567);
        put(1, 0, 64'h7FF7_FFFF_FFFF_FFFF);
        // R10: idle with changing inputs
        put(0, 1, 64'h7FF0_0000_0000_0001);
        put(0, 0, 64'h1234_5678_9ABC_DEF0);
        put(0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        put(1, 1, 64'h4000_0000_0000_0000);
        put(0, 0, 64'h7FF8_0000_0000_0001);
        for (int i = 0; i < 600; i++) begin
            logic [63:0] x;
            int cat;
            x = {$urandom, $urandom};
            cat = $urandom_range(0, 4);
            if (cat == 0) x[62:52] = '0;
            else if (cat >= 3) x[62:52] = '1;
            if (cat == 4 && ($urandom_range(0, 1) == 1)) x[50:0] = '0;
            if (x[62:52] == 11'h7FF && x[51:0] == '0 && cat == 4) x[0] = 1'b1;
            put($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, x);
        end
        put(0, 0, 64'd0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule